// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Target

This block is the target end of a five-wire firmware bus. The bus has a 4-bit bidirectional nibble lane and an active-low frame strobe. The block watches the lane for a start code, checks the device-select nibble against its own strap inputs, and shifts in a 28-bit address one nibble per clock. For a write it also takes in one data byte. It then hands each single-byte access to a simple byte-wide memory port, which has an address, a write byte, a read byte, one-clock read and write strobes, and a ready input.

On the bus side the block keeps to a fixed cycle layout. The host uses two clocks to hand the lane over. The target then drives a ready-sync nibble, and for a read it follows with the data, low nibble first. The target closes its part with an all-ones nibble and lets go of the lane. Tri-state control is shown as an output value plus an output enable. If the memory answers late, the target fills the sync slot with a wait nibble until the answer arrives.

Top module: `fwbus_target`

## Requirements
- R1: After reset, and for as long as the frame strobe stays high with no access under way, `lad_oe`, `mem_rd` and `mem_wr` stay low.
- R2: A nibble sampled while `frame_n` is low opens an access. 4'b1101 opens a read and 4'b1110 opens a write. Any other code leaves the block idle, so it never drives the lane and never strobes the memory.
- R3: When several start codes arrive in a row with `frame_n` low, only the last one before `frame_n` rises sets the access type.
- R4: The first nibble after the start code is the device select. If it differs from `dev_id`, the block drives nothing and strobes nothing for the whole access.
- R5: The next seven nibbles form the 28-bit address, most-significant nibble first. That address appears on `mem_addr` while the strobe is high.
- R6: The nibble after the address is the size field and must be 4'b0000. Any other value sends the block back to idle with no drive and no strobe.
- R7: In a read, counting the start nibble as clock 1, `lad_oe` is low in clocks 11 and 12. The sync nibble 4'b0000 comes next, then the data low nibble, the data high nibble, and 4'b1111. `lad_oe` is low again in the clock after that.
- R8: In a write, data nibbles 11 and 12 (low nibble first) form `mem_wdata`. `mem_wr` is high for exactly clock 13. `lad_oe` is low in clocks 13 and 14, and the sync nibble 4'b0000 is followed by 4'b1111 and then release.
- R9: A read raises `mem_rd` for exactly clock 11. The read byte is taken from `mem_rdata` in the clock where `mem_ready` is sampled high.
- R10: Until `mem_ready` has been sampled high after the strobe, each sync slot carries the wait nibble 4'b0110. Ready seen N clocks after a zero-latency reply gives exactly N wait nibbles before the 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields are sampled and driven on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble lane as seen at the pins |
| lad_out | output | 4 | Nibble the target drives onto the lane |
| lad_oe | output | 1 | High while the target drives the lane |
| dev_id | input | 4 | Strapped device-select value |
| mem_addr | output | 28 | Captured access address |
| mem_wdata | output | 8 | Captured write byte |
| mem_rdata | input | 8 | Read byte from the memory side |
| mem_rd | output | 1 | One-clock read strobe |
| mem_wr | output | 1 | One-clock write strobe |
| mem_ready | input | 1 | Memory side has completed the strobed access |

## Verification
The bench sends accesses that must be refused: a wrong device select, a non-zero size, and a start code that is not recognised. A target that filtered too loosely would drive the lane into the host's turnaround, or would pulse a memory strobe for an access meant for another device. A write code followed by a read code under one frame checks that the later code wins. A design that latched the first code would pulse `mem_wr` and fall silent on the lane. Memory replies with zero and with several clocks of latency check the wait-nibble count. A design that did not keep the ready flag would send 4'b0000 too early and return stale data. The address is sent with distinct nibbles so that a reversed shift order shows up in `mem_addr`.

// File: rtl/fwbus_pkg.sv
package fwbus_pkg;
  localparam int NIB_W = 4;
  localparam logic [3:0] CODE_RD   = 4'b1101;
  localparam logic [3:0] CODE_WR   = 4'b1110;
  localparam logic [3:0] SYNC_OK   = 4'b0000;
  localparam logic [3:0] SYNC_WAIT = 4'b0110;
  localparam logic [3:0] NIB_ONES  = 4'b1111;
  localparam logic [3:0] SIZE_ONE  = 4'b0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_SIZE, ST_WLO, ST_WHI,
    ST_TAR0, ST_TAR1, ST_SYNC, ST_DLO, ST_DHI, ST_TEND
  } fw_state_e;
endpackage

// File: rtl/fwbus_seq.sv
module fwbus_seq
  import fwbus_pkg::*;
#(
  parameter int ADDR_NIBS = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_n,
  input  logic [3:0] nib,
  input  logic [3:0] dev_id,
  input  logic      mem_ready,
  output fw_state_e st,
  output logic      op_wr,
  output logic      done,
  output logic      shift_addr,
  output logic      ld_lo,
  output logic      ld_hi,
  output logic      ld_rd,
  output logic      mem_rd,
  output logic      mem_wr
);
  localparam int CW = $clog2(ADDR_NIBS + 1);
  localparam logic [CW-1:0] LAST = CW'(ADDR_NIBS - 1);

  fw_state_e      st_n;
  logic           op_n, done_n, wait_win;
  logic [CW-1:0]  cnt, cnt_n;

  assign wait_win = (st == ST_TAR0) || (st == ST_TAR1) || (st == ST_SYNC);

  // next-state logic; a low frame strobe always restarts start decoding
  always_comb begin
    st_n  = st;
    op_n  = op_wr;
    cnt_n = cnt;
    if (!frame_n) begin
      if (nib == CODE_RD || nib == CODE_WR) begin
        st_n = ST_START;
        op_n = (nib == CODE_WR);
      end else begin
        st_n = ST_IDLE;
      end
    end else begin
      case (st)
        ST_IDLE:  st_n = ST_IDLE;
        ST_START: begin
          if (nib == dev_id) begin
            st_n  = ST_ADDR;
            cnt_n = '0;
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_ADDR:  begin
          if (cnt == LAST) st_n = ST_SIZE;
          else             cnt_n = cnt + 1'b1;
        end
        ST_SIZE:  begin
          if (nib != SIZE_ONE) st_n = ST_IDLE;
          else                 st_n = op_wr ? ST_WLO : ST_TAR0;
        end
        ST_WLO:   st_n = ST_WHI;
        ST_WHI:   st_n = ST_TAR0;
        ST_TAR0:  st_n = ST_TAR1;
        ST_TAR1:  st_n = ST_SYNC;
        ST_SYNC:  if (done) st_n = op_wr ? ST_TEND : ST_DLO;
        ST_DLO:   st_n = ST_DHI;
        ST_DHI:   st_n = ST_TEND;
        ST_TEND:  st_n = ST_IDLE;
        default:  st_n = ST_IDLE;
      endcase
    end
    done_n = wait_win && (done || mem_ready);
  end

  assign shift_addr = frame_n && (st == ST_ADDR);
  assign ld_lo      = frame_n && (st == ST_WLO);
  assign ld_hi      = frame_n && (st == ST_WHI);
  assign ld_rd      = wait_win && mem_ready && !done && !op_wr;
  assign mem_rd     = (st == ST_TAR0) && !op_wr;
  assign mem_wr     = (st == ST_TAR0) && op_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      op_wr <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      st    <= st_n;
      op_wr <= op_n;
      cnt   <= cnt_n;
      done  <= done_n;
    end
  end

  // R9: read strobe lasts one clock
  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R8: write strobe lasts one clock
  p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  // R10: once the memory has answered, the flag holds until the sync slot is left
  p_ack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st == ST_SYNC && frame_n) |=> (st != ST_SYNC));
endmodule

// File: rtl/fwbus_capture.sv
module fwbus_capture
  import fwbus_pkg::*;
#(
  parameter int ADDR_NIBS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NIB_W-1:0]           nib,
  input  logic                       shift_addr,
  input  logic                       ld_lo,
  input  logic                       ld_hi,
  input  logic                       ld_rd,
  input  logic [2*NIB_W-1:0]         rd_in,
  output logic [ADDR_NIBS*NIB_W-1:0] addr,
  output logic [2*NIB_W-1:0]         wdata,
  output logic [2*NIB_W-1:0]         rbuf
);
  localparam int AW = ADDR_NIBS * NIB_W;

  // address: most-significant nibble arrives first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr <= '0;
    else if (shift_addr) addr <= {addr[AW-NIB_W-1:0], nib};
  end

  // write byte: one enable per nibble slot, low slot first on the bus
  logic [1:0] slot_en;
  assign slot_en = {ld_hi, ld_lo};
  for (genvar g = 0; g < 2; g++) begin : g_wslot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wdata[g*NIB_W +: NIB_W] <= '0;
      else if (slot_en[g]) wdata[g*NIB_W +: NIB_W] <= nib;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rbuf <= '0;
    else if (ld_rd) rbuf <= rd_in;
  end
endmodule

// File: rtl/fwbus_target.sv
module fwbus_target
  import fwbus_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  localparam int AW = ADDR_NIBS * 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic [3:0]    lad_in,
  output logic [3:0]    lad_out,
  output logic          lad_oe,
  input  logic [3:0]    dev_id,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_ready
);
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  fw_state_e  st;
  logic       op_wr, done, shift_addr, ld_lo, ld_hi, ld_rd;
  logic [7:0] rbuf;

  fwbus_seq #(.ADDR_NIBS(ADDR_NIBS)) u_seq (
    .clk(clk), .rst_n(rst_s), .frame_n(frame_n), .nib(lad_in),
    .dev_id(dev_id), .mem_ready(mem_ready), .st(st), .op_wr(op_wr),
    .done(done), .shift_addr(shift_addr), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_rd(ld_rd), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  fwbus_capture #(.ADDR_NIBS(ADDR_NIBS)) u_cap (
    .clk(clk), .rst_n(rst_s), .nib(lad_in), .shift_addr(shift_addr),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_rd(ld_rd), .rd_in(mem_rdata),
    .addr(mem_addr), .wdata(mem_wdata), .rbuf(rbuf)
  );

  // lane drive: only in the target's own slots
  always_comb begin
    lad_oe  = 1'b1;
    lad_out = NIB_ONES;
    case (st)
      ST_SYNC: lad_out = done ? SYNC_OK : SYNC_WAIT;
      ST_DLO:  lad_out = rbuf[3:0];
      ST_DHI:  lad_out = rbuf[7:4];
      ST_TEND: lad_out = NIB_ONES;
      default: lad_oe  = 1'b0;
    endcase
  end

  // R7: the target leaves the lane only after driving all ones
  p_release_ones_r7: assert property (@(posedge clk) disable iff (!rst_s)
    ($fell(lad_oe) && $past(frame_n)) |-> ($past(lad_out) == NIB_ONES));
  // R7: a drive window spans at least sync plus one more nibble
  p_drive_min2_r7: assert property (@(posedge clk) disable iff (!rst_s)
    ($rose(lad_oe) && frame_n) |=> lad_oe);
  // R1: memory strobes never coincide with target drive
  p_strobe_quiet_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_rd || mem_wr) |-> !lad_oe);
  // R10: drive begins with a sync-class nibble
  p_first_sync_r10: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(lad_oe) |-> (lad_out == SYNC_OK || lad_out == SYNC_WAIT));
endmodule

// File: tb/fwbus_target_test.sv
module fwbus_target_test;
  logic        clk, rst_n, frame_n;
  logic [3:0]  lad_in, lad_out, dev_id;
  logic        lad_oe, mem_rd, mem_wr, mem_ready;
  logic [27:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  fwbus_target uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .dev_id(dev_id),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int oe_cnt = 0, rd_cnt = 0, wr_cnt = 0, mem_lat = 0, cd = 0;
  logic        pend = 1'b0;
  logic [27:0] last_ra = '0, last_wa = '0;
  logic [7:0]  last_wd = '0;
  logic        s_oe;
  logic [3:0]  s_out;

  // memory-side model
  always @(posedge clk) begin
    if (mem_rd) begin rd_cnt++; last_ra = mem_addr; end
    if (mem_wr) begin wr_cnt++; last_wa = mem_addr; last_wd = mem_wdata; end
    if (mem_rd || mem_wr) begin pend <= 1'b1; cd <= mem_lat; end
    else if (pend && cd > 0) cd <= cd - 1;
    else if (pend) pend <= 1'b0;
  end
  assign mem_ready = pend && (cd == 0);
  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // sample this clock's target output, then drive this clock's host nibble
  task automatic drive(input logic fr, input logic [3:0] v);
    @(negedge clk);
    s_oe = lad_oe; s_out = lad_out;
    if (lad_oe) oe_cnt++;
    frame_n = fr; lad_in = v;
  endtask

  task automatic wait_sync(output int waits, output int bad);
    waits = 0; bad = 0;
    drive(1'b1, 4'hF);
    while (!(s_oe && s_out == 4'h0) && waits < 40) begin
      if (!(s_oe && s_out == 4'h6)) bad++;
      waits++;
      drive(1'b1, 4'hF);
    end
  endtask

  task automatic do_read(input bit pre, input logic [3:0] code, input logic [3:0] id,
                         input logic [27:0] a, input logic [3:0] size, input int lat,
                         input bit resp, input string rq);
    int rd0, oe0, waits, bad;
    logic [7:0] exp;
    exp = a[7:0] ^ 8'h5A;
    mem_lat = lat; rd0 = rd_cnt; oe0 = oe_cnt;
    if (pre) drive(1'b0, 4'hE);
    drive(1'b0, code);
    drive(1'b1, id);
    for (int i = 6; i >= 0; i--) drive(1'b1, a[i*4 +: 4]);
    drive(1'b1, size);
    if (!resp) begin
      repeat (10) drive(1'b1, 4'hF);
      chk(oe_cnt == oe0, rq, "lane driven on refused access", oe_cnt - oe0, 0);
      chk(rd_cnt == rd0 && wr_cnt == wr_cnt, rq, "strobe on refused access", rd_cnt - rd0, 0);
      return;
    end
    drive(1'b1, 4'hF);
    chk(!s_oe, "R7", "oe in host turnaround clock", s_oe, 0);
    drive(1'b1, 4'hF);
    chk(!s_oe, "R7", "oe in float clock", s_oe, 0);
    wait_sync(waits, bad);
    chk(waits == lat, "R10", "wait nibble count", waits, lat);
    chk(bad == 0, "R10", "non-wait nibble before sync", bad, 0);
    drive(1'b1, 4'hF);
    chk(s_oe && s_out == exp[3:0], "R7", "data low nibble", {s_oe, s_out}, {1'b1, exp[3:0]});
    drive(1'b1, 4'hF);
    chk(s_oe && s_out == exp[7:4], "R7", "data high nibble", {s_oe, s_out}, {1'b1, exp[7:4]});
    drive(1'b1, 4'hF);
    chk(s_oe && s_out == 4'hF, "R7", "closing ones", {s_oe, s_out}, 5'h1F);
    drive(1'b1, 4'hF);
    chk(!s_oe, "R7", "release after ones", s_oe, 0);
    chk(rd_cnt - rd0 == 1, "R9", "read strobe count", rd_cnt - rd0, 1);
    chk(last_ra == a, "R5", "address at read strobe", last_ra, a);
  endtask

  task automatic do_write(input logic [3:0] id, input logic [27:0] a,
                          input logic [7:0] d, input int lat);
    int wr0, waits, bad;
    mem_lat = lat; wr0 = wr_cnt;
    drive(1'b0, 4'hE);
    drive(1'b1, id);
    for (int i = 6; i >= 0; i--) drive(1'b1, a[i*4 +: 4]);
    drive(1'b1, 4'h0);
    drive(1'b1, d[3:0]);
    drive(1'b1, d[7:4]);
    drive(1'b1, 4'hF);
    chk(!s_oe && mem_wr, "R8", "write strobe in clock 13, lane free", {s_oe, mem_wr}, 2'b01);
    drive(1'b1, 4'hF);
    chk(!s_oe && !mem_wr, "R8", "clock 14 float, strobe gone", {s_oe, mem_wr}, 2'b00);
    wait_sync(waits, bad);
    chk(waits == lat && bad == 0, "R10", "write wait nibbles", waits, lat);
    drive(1'b1, 4'hF);
    chk(s_oe && s_out == 4'hF, "R8", "closing ones", {s_oe, s_out}, 5'h1F);
    drive(1'b1, 4'hF);
    chk(!s_oe, "R8", "release", s_oe, 0);
    chk(wr_cnt - wr0 == 1, "R8", "write strobe count", wr_cnt - wr0, 1);
    chk(last_wd == d, "R8", "write byte", last_wd, d);
    chk(last_wa == a, "R5", "write address", last_wa, a);
  endtask

  task automatic t_reset_idle();
    int oe0;
    @(negedge clk);
    chk(!lad_oe && !mem_rd && !mem_wr, "R1", "reset outputs", {lad_oe, mem_rd, mem_wr}, 0);
    oe0 = oe_cnt;
    drive(1'b1, 4'hD); drive(1'b1, 4'hE); drive(1'b1, 4'h9);
    repeat (3) drive(1'b1, 4'hF);
    chk(oe_cnt == oe0 && rd_cnt == 0 && wr_cnt == 0, "R1", "standby quiet with frame high",
        oe_cnt - oe0 + rd_cnt + wr_cnt, 0);
  endtask

  task automatic t_last_start();
    int wr0;
    wr0 = wr_cnt;
    do_read(1'b1, 4'hD, 4'h9, 28'h0A1B2C3, 4'h0, 0, 1'b1, "R3");
    chk(wr_cnt == wr0, "R3", "earlier write code discarded", wr_cnt - wr0, 0);
  endtask

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; lad_in = 4'hF; dev_id = 4'h9;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset_idle();                                                   // R1
    do_read(1'b0, 4'hD, 4'h9, 28'h1234567, 4'h0, 0, 1'b1, "R7");       // R2 R5 R7 R9
    do_read(1'b0, 4'hD, 4'h9, 28'hFEDCBA9, 4'h0, 3, 1'b1, "R10");      // R10
    do_write(4'h9, 28'h7654321, 8'hC3, 0);                             // R8
    do_write(4'h9, 28'h0000ABC, 8'h5E, 2);                             // R8 R10
    do_read(1'b0, 4'hD, 4'h3, 28'h1111111, 4'h0, 0, 1'b0, "R4");       // R4
    do_read(1'b0, 4'hD, 4'h9, 28'h2222222, 4'h1, 0, 1'b0, "R6");       // R6
    do_read(1'b0, 4'h0, 4'h9, 28'h3333333, 4'h0, 0, 1'b0, "R2");       // R2 unknown code
    t_last_start();                                                   // R3
    dev_id = 4'h2;
    do_read(1'b0, 4'hD, 4'h2, 28'h89ABCDE, 4'h0, 1, 1'b1, "R4");       // R4 new strap
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule